// File: doc/BRIEF.md
# Bayer defect pixel corrector

This block sits in a raw-pixel stream and repairs isolated bad pixels as they pass. It takes 10-bit Bayer samples one at a time, marked by a valid strobe and a line-start flag. Each pixel is compared with the two nearest pixels of the same colour on its row. In a Bayer row the colours alternate, so those two pixels sit two columns to the left and two columns to the right. A pixel that stands out from both of them by more than a programmable threshold, either brighter than both or darker than both, is treated as a defect. It is then replaced by the rounded mean of those two neighbours.

Detection runs on every pixel and the block keeps no list of known defects, so the number of pixels it can repair per frame has no limit. The stream leaves the block delayed by two pixel positions. Line ends are not signalled: a line ends when the next line-start arrives. The two pixels at each end of a line lack a same-colour neighbour on one side, so they pass through unchanged. An enable input turns the repair off without changing the delay.

Top module: `bayer_defect_fix`

## Requirements
- R1: While reset is active, and until three pixels have been accepted after it, `out_valid` and `out_sol` stay low.
- R2: Each accepted pixel at stream position k is presented on the outputs, with `out_valid` high for one cycle, two clock cycles after the pixel at position k+2 is accepted. In every other cycle `out_valid` is low.
- R3: `out_sol` is high exactly when the pixel being presented was accepted with `in_sol` high, and never without `out_valid`.
- R4: A hot pixel is replaced by (left + right + 1) >> 1, where left and right are the samples two positions before and after it in the same line. A pixel is hot when its value exceeds both left + threshold and right + threshold.
- R5: A cold pixel is replaced by the same mean. A pixel is cold when its value plus threshold is less than both left and right.
- R6: A pixel that differs from a neighbour by exactly the threshold is not corrected. The comparison is strict.
- R7: A pixel that is above one same-colour neighbour and below the other passes unchanged, however large the differences.
- R8: The first two and the last two pixels of each line pass unchanged. The last two pixels of a line are the two accepted just before the next pixel with `in_sol` high.
- R9: With `enable` low, every pixel passes unchanged, with the same timing as in R2.
- R10: Any number of defects per line is corrected, provided each defect's two same-colour neighbours are not themselves defects.
- R11: The sum and the rounding are computed one bit wider than a pixel. For example, neighbours 1022 and 1023 give 1023, and neighbours 0 and 1 give 1.
- R12: Idle cycles between valid pixels change neither the pixel values presented nor the pairing of neighbours.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | 1 = repair defects, 0 = pass through |
| threshold | input | 10 | Outlier margin compared against both neighbours |
| in_valid | input | 1 | Input pixel present this cycle |
| in_sol | input | 1 | Input pixel is the first of a line |
| in_pix | input | 10 | Input raw sample |
| out_valid | output | 1 | Output pixel present this cycle |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_pix | output | 10 | Output sample, repaired or passed through |

## Verification
The main function is driven with three kinds of line. Lines with a single bright or dark spike show whether both outlier directions are detected. Lines whose spike sits exactly at the threshold or one step beyond it separate a strict comparison from an inclusive one. Lines with a slope, where the pixel lies between its neighbours, show that only outliers on both sides trigger a repair. Further cases cover lines with many separated defects, lines with extreme neighbour values that expose any lost carry in the mean, spikes placed at line ends, very short lines, and the same spike line with repair disabled or with idle gaps between pixels. Each of these shows whether line boundaries, bypass and gaps leave the neighbour pairing and the delay intact.

// File: rtl/dpc_pkg.sv
package dpc_pkg;

    // Verdict for the pixel in the centre of the window
    typedef enum logic [1:0] {
        CLS_KEEP = 2'd0,   // interior pixel, not an outlier (or bypassed)
        CLS_HOT  = 2'd1,   // above both same-colour neighbours by > margin
        CLS_COLD = 2'd2,   // below both same-colour neighbours by > margin
        CLS_EDGE = 2'd3    // a neighbour is missing in this line
    } dpc_class_e;

endpackage

// File: rtl/dpc_window.sv
module dpc_window #(
    parameter int PIX_W = 10,
    parameter int PITCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_i,
    input  logic             sol_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic [PIX_W-1:0] left_o,
    output logic [PIX_W-1:0] ctr_o,
    output logic [PIX_W-1:0] right_o,
    output logic             ctr_sol_o,
    output logic             ctr_occ_o,
    output logic             fresh_o,
    output logic             left_ok_o,
    output logic             right_ok_o
);

    localparam int DEPTH = 2 * PITCH + 1;
    localparam int LAST  = DEPTH - 1;

    // index 0 = newest sample (right neighbour), PITCH = centre, LAST = left
    typedef struct packed {
        logic [DEPTH-1:0][PIX_W-1:0] pix;
        logic [DEPTH-1:0]            sol;
        logic [DEPTH-1:0]            occ;
        logic                        fresh;
    } win_t;

    win_t win_d, win_q;

    always_comb begin
        win_d       = win_q;
        win_d.fresh = shift_i;
        if (shift_i) begin
            for (int k = LAST; k > 0; k--) begin
                win_d.pix[k] = win_q.pix[k-1];
                win_d.sol[k] = win_q.sol[k-1];
                win_d.occ[k] = win_q.occ[k-1];
            end
            win_d.pix[0] = pix_i;
            win_d.sol[0] = sol_i;
            win_d.occ[0] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    // Same-line test: a line start between centre and a neighbour breaks the pair
    logic [PITCH-1:0] left_break, right_break;

    for (genvar g = 0; g < PITCH; g++) begin : g_breaks
        assign left_break[g]  = win_q.sol[PITCH + g];
        assign right_break[g] = win_q.sol[g];
    end

    assign left_ok_o  = win_q.occ[LAST] && (left_break == '0);
    assign right_ok_o = win_q.occ[0] && (right_break == '0);
    assign left_o     = win_q.pix[LAST];
    assign ctr_o      = win_q.pix[PITCH];
    assign right_o    = win_q.pix[0];
    assign ctr_sol_o  = win_q.sol[PITCH];
    assign ctr_occ_o  = win_q.occ[PITCH];
    assign fresh_o    = win_q.fresh;

endmodule

// File: rtl/dpc_classify.sv
module dpc_classify
    import dpc_pkg::*;
#(
    parameter int PIX_W = 10
) (
    input  logic             enable_i,
    input  logic [PIX_W-1:0] margin_i,
    input  logic [PIX_W-1:0] left_i,
    input  logic [PIX_W-1:0] ctr_i,
    input  logic [PIX_W-1:0] right_i,
    input  logic             left_ok_i,
    input  logic             right_ok_i,
    output dpc_class_e       cls_o,
    output logic [PIX_W-1:0] pix_o
);

    localparam int WIDE = PIX_W + 1;

    logic [WIDE-1:0] l_w, c_w, r_w, m_w;
    logic [WIDE-1:0] mean_w;
    logic            hot, cold;

    always_comb begin
        l_w    = {1'b0, left_i};
        c_w    = {1'b0, ctr_i};
        r_w    = {1'b0, right_i};
        m_w    = {1'b0, margin_i};
        hot    = (c_w > l_w + m_w) && (c_w > r_w + m_w);
        cold   = (c_w + m_w < l_w) && (c_w + m_w < r_w);
        mean_w = (l_w + r_w + WIDE'(1)) >> 1;

        if (!(left_ok_i && right_ok_i)) cls_o = CLS_EDGE;
        else if (!enable_i)             cls_o = CLS_KEEP;
        else if (hot)                   cls_o = CLS_HOT;
        else if (cold)                  cls_o = CLS_COLD;
        else                            cls_o = CLS_KEEP;

        if (cls_o == CLS_HOT || cls_o == CLS_COLD) pix_o = mean_w[PIX_W-1:0];
        else                                       pix_o = ctr_i;
    end

endmodule

// File: rtl/bayer_defect_fix.sv
module bayer_defect_fix
    import dpc_pkg::*;
#(
    parameter int PIX_W       = 10,
    parameter int COLOR_PITCH = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [PIX_W-1:0] threshold,
    input  logic             in_valid,
    input  logic             in_sol,
    input  logic [PIX_W-1:0] in_pix,
    output logic             out_valid,
    output logic             out_sol,
    output logic [PIX_W-1:0] out_pix
);

    typedef struct packed {
        logic             valid;
        logic             sol;
        logic [PIX_W-1:0] pix;
    } out_t;

    out_t out_d, out_q;

    logic [PIX_W-1:0] w_left, w_ctr, w_right, fix_pix;
    logic             w_sol, w_occ, w_fresh, w_lok, w_rok;
    dpc_class_e       cls;

    dpc_window #(.PIX_W(PIX_W), .PITCH(COLOR_PITCH)) u_window (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_i    (in_valid),
        .sol_i      (in_sol),
        .pix_i      (in_pix),
        .left_o     (w_left),
        .ctr_o      (w_ctr),
        .right_o    (w_right),
        .ctr_sol_o  (w_sol),
        .ctr_occ_o  (w_occ),
        .fresh_o    (w_fresh),
        .left_ok_o  (w_lok),
        .right_ok_o (w_rok)
    );

    dpc_classify #(.PIX_W(PIX_W)) u_classify (
        .enable_i   (enable),
        .margin_i   (threshold),
        .left_i     (w_left),
        .ctr_i      (w_ctr),
        .right_i    (w_right),
        .left_ok_i  (w_lok),
        .right_ok_i (w_rok),
        .cls_o      (cls),
        .pix_o      (fix_pix)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = w_fresh && w_occ;
        out_d.sol   = 1'b0;
        if (w_fresh && w_occ) begin
            out_d.sol = w_sol;
            out_d.pix = fix_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_sol   = out_q.sol;
    assign out_pix   = out_q.pix;

    AST_OUT_AFTER_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 2)); // R2

    AST_SOL_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        out_sol |-> out_valid); // R3

    AST_HOT_LOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(cls == CLS_HOT) |-> out_pix < $past(w_ctr)); // R4

    AST_COLD_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(cls == CLS_COLD) |-> out_pix > $past(w_ctr)); // R5

    AST_EDGE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(cls == CLS_EDGE) |-> out_pix == $past(w_ctr)); // R8

    AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !$past(enable) |-> out_pix == $past(w_ctr)); // R9

    AST_MEAN_BETWEEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && $past(cls == CLS_HOT || cls == CLS_COLD) |->
            (out_pix >= $past(w_left) || out_pix >= $past(w_right)) &&
            (out_pix <= $past(w_left) || out_pix <= $past(w_right))); // R11

endmodule

// File: tb/bayer_defect_fix_test.sv
`timescale 1ns/1ps
module bayer_defect_fix_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic [9:0] threshold = '0;
    logic       in_valid = 1'b0;
    logic       in_sol = 1'b0;
    logic [9:0] in_pix = '0;
    logic       out_valid, out_sol;
    logic [9:0] out_pix;

    always #2.5 clk = ~clk;

    bayer_defect_fix uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .threshold(threshold),
        .in_valid(in_valid), .in_sol(in_sol), .in_pix(in_pix),
        .out_valid(out_valid), .out_sol(out_sol), .out_pix(out_pix)
    );

    int    checks = 0;
    int    errors = 0;
    int    acc_cnt = 0;
    bit    acc_prev = 1'b0;
    bit    mon_on = 1'b0;
    bit    done = 1'b0;
    int    exp_pix[$];
    bit    exp_sol[$];
    string exp_tag[$];
    int    lb[64];

    // Output monitor: timing (R2) and value/line-start comparison
    always @(posedge clk) begin
        #1;
        if (mon_on) begin
            checks++;
            if (out_valid !== (acc_prev && acc_cnt >= 3)) begin
                errors++;
                $display("FAIL R2: out_valid actual %0b expected %0b", out_valid, acc_prev && acc_cnt >= 3);
            end
            if (out_valid === 1'b1) begin
                if (exp_pix.size() == 0) begin
                    checks++; errors++;
                    $display("FAIL R2: unexpected output actual %0d expected none", out_pix);
                end else begin
                    int    e_p;
                    bit    e_s;
                    string e_t;
                    e_p = exp_pix.pop_front();
                    e_s = exp_sol.pop_front();
                    e_t = exp_tag.pop_front();
                    checks++;
                    if (int'(out_pix) != e_p) begin
                        errors++;
                        $display("FAIL %s: out_pix actual %0d expected %0d", e_t, out_pix, e_p);
                    end
                    checks++;
                    if (out_sol !== e_s) begin
                        errors++;
                        $display("FAIL R3: out_sol actual %0b expected %0b", out_sol, e_s);
                    end
                end
            end
            acc_prev = in_valid;
            if (in_valid) acc_cnt++;
        end
    end

    task automatic send_pix(input int v, input bit s);
        @(negedge clk);
        in_valid = 1'b1;
        in_pix   = 10'(v);
        in_sol   = s;
    endtask

    task automatic go_idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_sol   = 1'b0;
    endtask

    // Drives lb[0..n-1] as one line, then a two-pixel flush line
    task automatic drive_line(input int n, input int gap, input string tag);
        int th;
        th = int'(threshold);
        for (int i = 0; i < n; i++) begin
            int v;
            v = lb[i];
            if (i >= 2 && i <= n - 3 && enable) begin
                int l, c, r;
                l = lb[i-2]; c = lb[i]; r = lb[i+2];
                if ((c > l + th && c > r + th) || (c + th < l && c + th < r))
                    v = (l + r + 1) / 2;
            end
            exp_pix.push_back(v);
            exp_sol.push_back(i == 0);
            exp_tag.push_back((i < 2 || i > n - 3) ? "R8" : tag);
        end
        for (int i = 0; i < n; i++) begin
            send_pix(lb[i], i == 0);
            for (int g = 0; g < gap; g++) go_idle();
        end
        exp_pix.push_back(7); exp_sol.push_back(1'b1); exp_tag.push_back("R8");
        exp_pix.push_back(8); exp_sol.push_back(1'b0); exp_tag.push_back("R8");
        send_pix(7, 1'b1);
        send_pix(8, 1'b0);
        go_idle();
        repeat (4) @(negedge clk);
        checks++;
        if (exp_pix.size() != 2) begin
            errors++;
            $display("FAIL %s: pending outputs actual %0d expected 2", tag, exp_pix.size());
        end
    endtask

    task automatic fill_flat(input int n, input int v);
        for (int i = 0; i < n; i++) lb[i] = v;
    endtask

    task automatic t_reset();
        for (int k = 0; k < 3; k++) begin
            @(posedge clk); #1;
            checks++;
            if (out_valid !== 1'b0 || out_sol !== 1'b0) begin
                errors++;
                $display("FAIL R1: valid/sol actual %0b/%0b expected 0/0", out_valid, out_sol);
            end
        end
    endtask

    task automatic t_hot();
        enable = 1'b1; threshold = 10'd20;
        fill_flat(12, 100); lb[3] = 100; lb[7] = 110; lb[5] = 500;
        drive_line(12, 0, "R4");
    endtask

    task automatic t_cold();
        enable = 1'b1; threshold = 10'd20;
        fill_flat(12, 600); lb[6] = 3; lb[4] = 640;
        drive_line(12, 0, "R5");
    endtask

    task automatic t_threshold();
        enable = 1'b1; threshold = 10'd30;
        fill_flat(14, 200); lb[4] = 230; lb[9] = 231; lb[11] = 169;
        drive_line(14, 0, "R6");
    endtask

    task automatic t_mixed();
        enable = 1'b1; threshold = 10'd0;
        for (int i = 0; i < 12; i++) lb[i] = 80 * i + 10;
        lb[5] = 1000; lb[3] = 5; lb[7] = 1020;
        drive_line(12, 0, "R7");
    endtask

    task automatic t_many();
        enable = 1'b1; threshold = 10'd10;
        fill_flat(16, 300);
        lb[3] = 900; lb[4] = 20; lb[7] = 1023; lb[8] = 0; lb[11] = 700; lb[12] = 50;
        drive_line(16, 0, "R10");
    endtask

    task automatic t_rounding();
        enable = 1'b1; threshold = 10'd0;
        lb[0] = 1022; lb[1] = 0; lb[2] = 0; lb[3] = 1023; lb[4] = 1023;
        lb[5] = 1; lb[6] = 0; lb[7] = 1023; lb[8] = 1; lb[9] = 1023; lb[10] = 1023;
        drive_line(11, 0, "R11");
    endtask

    task automatic t_edges();
        enable = 1'b1; threshold = 10'd5;
        fill_flat(10, 400); lb[0] = 1000; lb[1] = 2; lb[8] = 900; lb[9] = 0;
        drive_line(10, 0, "R8");
        lb[0] = 10; lb[1] = 900; lb[2] = 10;
        drive_line(3, 0, "R8");
    endtask

    task automatic t_disabled();
        enable = 1'b0; threshold = 10'd20;
        fill_flat(12, 100); lb[5] = 500; lb[6] = 0;
        drive_line(12, 0, "R9");
    endtask

    task automatic t_gaps();
        enable = 1'b1; threshold = 10'd20;
        fill_flat(12, 250); lb[5] = 800; lb[6] = 1; lb[3] = 260;
        drive_line(12, 2, "R12");
    endtask

    initial begin
        #(5.0 * 50000);
        if (!done) begin
            errors++;
            $display("FAIL R2: watchdog actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n  = 1'b1;
        mon_on = 1'b1;
        t_reset();
        t_hot();
        t_cold();
        t_threshold();
        t_mixed();
        t_many();
        t_rounding();
        t_edges();
        t_disabled();
        t_gaps();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule